// File: doc/BRIEF.md
# Configuration Output Select, Hold and Force-Low Stage

This block drives six open-drain configuration lines from two sources. Five of the lines are multiplexed: a select input chooses between a 6-bit stored configuration word, using its five low bits, and five external strap pins. The sixth line carries the top bit of the stored word through a hold stage. That stage passes the bit while the select is low and freezes it while the select is high. An active-low force input pulls every line low, but only while the select is low. While the select is high, the pins and the held bit stay in force.

Each line is given as a logic value and as a drive-low enable. The drive-low enable is the inverse of the logic value, so a logic 1 means the pad is released to an external pull-up. The select is synchronised into the block clock domain, and the hold stage is a clocked register, so the design contains no inferred latch. The stored word comes from outside the block.

Top module: `cfg_out_stage`

## Requirements
- R1: With the synchronised select low and the force input high, mux_o[i] equals store_i[i] for i = 0..4.
- R2: With the synchronised select high, mux_o equals pin_i, whatever the values of force_ni and store_i.
- R3: With the synchronised select low and the force input high, hold_o equals store_i[5] in the same cycle (transparent).
- R4: While the synchronised select stays high, hold_o keeps the value it showed in the last cycle before the select rose, and changes to store_i or force_ni do not affect it.
- R5: With the synchronised select low and force_ni low, mux_o is 0 and hold_o is 0.
- R6: mux_drv_o equals ~mux_o and hold_drv_o equals ~hold_o; a drive enable of 1 pulls the pad low and 0 releases it.
- R7: A change on sel_i reaches the outputs after exactly SYNC_STAGES rising clock edges (default 2), and no earlier.
- R8: During and directly after reset, the synchronised select is low, so the outputs come from store_i as in R1, R3 and R5.
- R9: When reset is released with sel_i already high, the hold stage is loaded from store_i[5] (gated by force_ni) during the transparent cycles before the select takes effect. After that it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Source select: 0 stored word, 1 pins; also closes the hold stage |
| force_ni | input | 1 | Active-low force of all outputs low, honoured only while select is low |
| store_i | input | MUX_W+1 | Stored word: bits [MUX_W-1:0] multiplexed, bit MUX_W held |
| pin_i | input | MUX_W | External strap inputs |
| mux_o | output | MUX_W | Multiplexed output logic values |
| mux_drv_o | output | MUX_W | Drive-low enables for the multiplexed outputs |
| hold_o | output | 1 | Held output logic value |
| hold_drv_o | output | 1 | Drive-low enable for the held output |

## Verification
Assertions check on every cycle that the pins pass through while the select is high, and that the stored bits pass through while the select is low. They also check that the force pulls all six lines low, that each drive enable is the inverse of its value, and that the held bit does not move while the select stays high. Some properties depend on history, and only the bench scenarios show them. These are which value is captured when the select rises, the exact number of edges a select change needs, and how the hold stage is loaded after reset with the select already high. The bench sweeps every stored word against the pins and the force input in both select states.

// File: rtl/cfg_out_pkg.sv
package cfg_out_pkg;
  typedef enum logic {
    SRC_STORE = 1'b0,
    SRC_PIN   = 1'b1
  } src_e;
endpackage

// File: rtl/cfg_sel_sync.sv
module cfg_sel_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic sel_s_o
);
  logic [SYNC_STAGES-1:0] chain_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= sel_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[SYNC_STAGES-2:0], sel_i};
      end
    end
  endgenerate

  assign sel_s_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/cfg_mux_path.sv
module cfg_mux_path
  import cfg_out_pkg::*;
#(
  parameter int unsigned MUX_W = 5
) (
  input  src_e             src_i,
  input  logic             force_ni,
  input  logic [MUX_W-1:0] store_i,
  input  logic [MUX_W-1:0] pin_i,
  output logic [MUX_W-1:0] val_o,
  output logic [MUX_W-1:0] drv_o
);
  for (genvar i = 0; i < MUX_W; i++) begin : g_bit
    logic pick;
    always_comb begin
      if (src_i == SRC_PIN) pick = pin_i[i];
      else                  pick = store_i[i] & force_ni;
    end
    assign val_o[i] = pick;
    assign drv_o[i] = ~pick;
  end
endmodule

// File: rtl/cfg_hold_latch.sv
module cfg_hold_latch
  import cfg_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e src_i,
  input  logic force_ni,
  input  logic bit_i,
  output logic val_o,
  output logic drv_o
);
  logic live;
  logic held_q;

  assign live = bit_i & force_ni;

  // follows the shown value while open, so the edge captures it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  held_q <= 1'b0;
    else if (src_i == SRC_STORE)  held_q <= live;
  end

  assign val_o = (src_i == SRC_PIN) ? held_q : live;
  assign drv_o = ~val_o;

  // R4
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == SRC_PIN && $past(src_i) == SRC_PIN) |-> $stable(val_o));
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage
  import cfg_out_pkg::*;
#(
  parameter int unsigned MUX_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             force_ni,
  input  logic [MUX_W:0]   store_i,
  input  logic [MUX_W-1:0] pin_i,
  output logic [MUX_W-1:0] mux_o,
  output logic [MUX_W-1:0] mux_drv_o,
  output logic             hold_o,
  output logic             hold_drv_o
);
  localparam int unsigned HoldIdx = MUX_W;

  logic sel_s;
  src_e src;

  cfg_sel_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .sel_s_o(sel_s)
  );

  assign src = sel_s ? SRC_PIN : SRC_STORE;

  cfg_mux_path #(.MUX_W(MUX_W)) u_mux (
    .src_i   (src),
    .force_ni(force_ni),
    .store_i (store_i[MUX_W-1:0]),
    .pin_i   (pin_i),
    .val_o   (mux_o),
    .drv_o   (mux_drv_o)
  );

  cfg_hold_latch u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src),
    .force_ni(force_ni),
    .bit_i   (store_i[HoldIdx]),
    .val_o   (hold_o),
    .drv_o   (hold_drv_o)
  );

  // R1
  store_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_s && force_ni) |-> (mux_o == store_i[MUX_W-1:0]));
  // R2
  pin_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_s |-> (mux_o == pin_i));
  // R5
  force_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_s && !force_ni) |-> (mux_o == '0 && !hold_o));
  // R6
  drv_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_drv_o == ~mux_o) && (hold_drv_o == !hold_o));
endmodule

// File: tb/cfg_out_stage_bench.sv
module cfg_out_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic frc_n = 1'b1;
  logic [MW:0] store = '0;
  logic [MW-1:0] pins = '0;
  logic [MW-1:0] mux, mux_drv;
  logic hold, hold_drv;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_out_stage u_cfg_out_stage (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .force_ni(frc_n),
    .store_i(store), .pin_i(pins), .mux_o(mux), .mux_drv_o(mux_drv),
    .hold_o(hold), .hold_drv_o(hold_drv)
  );

  // pad model: released line pulled high
  wire [MW-1:0] pad_mux = ~mux_drv;
  wire          pad_hold = ~hold_drv;

  task automatic chk(input string tag, input logic [MW:0] got, input logic [MW:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check_open(input string tag);
    logic [MW-1:0] em;
    logic eh;
    em = frc_n ? store[MW-1:0] : '0;
    eh = frc_n & store[MW];
    chk(tag, {hold, mux}, {eh, em});
    // R6
    chk("R6", {hold_drv, mux_drv}, ~{eh, em});
    chk("R6_pad", {pad_hold, pad_mux}, {eh, em});
  endtask

  task automatic hold_case(input logic b5, input logic f);
    logic exp_h;
    sel = 1'b0; frc_n = f; store = {b5, 5'h0A};
    step(4);
    exp_h = b5 & f;
    sel = 1'b1;
    step(4);
    for (int fv = 0; fv < 2; fv++)
      for (int s = 0; s < 64; s++) begin
        frc_n = fv[0]; store = s[MW:0]; pins = s[MW-1:0] ^ 5'h15;
        step(1);
        // R4
        chk("R4", {5'h0, hold}, {5'h0, exp_h});
        // R2
        chk("R2", {1'b0, mux}, {1'b0, pins});
      end
    sel = 1'b0; frc_n = 1'b1; store = 6'h21;
    step(3);
    check_open("R3_reopen");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog got=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    store = 6'h2A; pins = 5'h1F;
    step(2);
    // R8
    check_open("R8_in_reset");
    rst_n = 1'b1;
    step(1);
    check_open("R8_after_reset");

    // R1 R3 R5 sweep
    for (int fv = 0; fv < 2; fv++)
      for (int s = 0; s < 64; s++)
        for (int p = 0; p < 32; p++) begin
          frc_n = fv[0]; store = s[MW:0]; pins = p[MW-1:0];
          step(1);
          check_open(fv ? "R1_R3" : "R5");
        end

    // R7 latency
    frc_n = 1'b1; store = 6'h00; pins = 5'h1F; sel = 1'b0;
    step(3);
    sel = 1'b1;
    step(1);
    chk("R7_early", {1'b0, mux}, 6'h00);
    step(1);
    chk("R7_taken", {1'b0, mux}, 6'h1F);
    sel = 1'b0;
    step(1);
    chk("R7_fall_early", {1'b0, mux}, 6'h1F);
    step(1);
    chk("R7_fall_taken", {1'b0, mux}, 6'h00);

    hold_case(1'b1, 1'b1);
    hold_case(1'b0, 1'b1);
    hold_case(1'b1, 1'b0);

    // R9: reset release with select already high
    sel = 1'b1; frc_n = 1'b1; store = 6'h20;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(6);
    chk("R9_loaded", {5'h0, hold}, 6'h01);
    store = 6'h00; frc_n = 1'b0;
    step(2);
    chk("R9_held", {5'h0, hold}, 6'h01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule